// File: doc/BRIEF.md
# Sixteen-Bit Capture/Reload Timer with Serial Baud Strobes

This block is a 16-bit up-counter with a companion 16-bit capture/reload register and an 8-bit control register. Software reaches all three through a small register bus. The counter advances in one of two ways. In timer mode it steps on a prescaled tick. In counter mode it steps on falling edges of an external count pin.

When the counter wraps, one of two things happens. In auto-reload mode it loads the companion register. In capture mode it rolls over to zero. A separate external trigger pin, when enabled, either copies the counter into the companion register (capture) or forces a reload.

When either serial clock select bit is set, the block acts as a baud-rate generator. In that case:
- it always reloads on overflow;
- the trigger pin is ignored;
- the overflow flag is held off;
- every overflow produces a one-cycle strobe on the receive and/or transmit baud outputs, for use by a serial port.

Top module: `cr_timer16`

## Requirements
- R1: After synchronous reset, the control, counter and capture/reload registers all read 0 and `irq_o` is low.
- R2: Registers are selected by `bus_addr` and read combinationally on `bus_rdata`.
  - Address 0 is control, zero-extended. Its bits are: bit 7 overflow flag, bit 6 trigger flag, bit 5 receive baud select, bit 4 transmit baud select, bit 3 trigger enable, bit 2 run, bit 1 count-pin select, bit 0 capture mode.
  - Address 1 is the counter.
  - Address 2 is the capture/reload register.
  - A write takes effect at the clock edge on which `bus_wr` is high.
- R3: With run=1 and count-pin select=0, the counter increments once per cycle in which `tick_i` is high. With run=0, ticks do not change it.
- R4: With run=1 and count-pin select=1, the counter increments once per high-to-low transition of `count_pin_i`, seen through a two-flop synchronizer. `tick_i` is then ignored.
- R5: A count step from 0xFFFF sets the overflow flag (bit 7). Hardware never clears it; only a bus write does.
- R6: On overflow with capture mode=0, the counter loads the capture/reload value. With capture mode=1 and both baud selects at 0, the counter rolls to 0x0000.
- R7: With trigger enable=1 and both baud selects at 0, a synchronized falling edge on `trig_pin_i` has these effects:
  - it sets the trigger flag (bit 6);
  - with capture mode=0, it reloads the counter;
  - with capture mode=1, it copies the counter into the capture/reload register.
- R8: With trigger enable=0, trigger edges change neither flag nor register.
- R9: With either baud select set, the block behaves as follows:
  - capture mode is ignored and overflow reloads;
  - the overflow flag is not set;
  - trigger edges have no effect.
- R10: Each overflow in auto-reload operation produces a one-cycle pulse on `rx_baud_o` if bit 5 is set, and on `tx_baud_o` if bit 4 is set. The pulse appears in the cycle after the overflow edge. An overflow in capture mode with no baud select produces no pulse.
- R11: `irq_o` is high exactly when the overflow flag or the trigger flag is set.
- R12: A bus write to the counter wins over a count step in the same cycle. A hardware flag set wins over a bus write of 0 to that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| tick_i | input | 1 | Prescaled timer tick |
| count_pin_i | input | 1 | External count pin (asynchronous) |
| trig_pin_i | input | 1 | External trigger pin (asynchronous) |
| irq_o | output | 1 | Interrupt request |
| rx_baud_o | output | 1 | Receive baud strobe |
| tx_baud_o | output | 1 | Transmit baud strobe |

## Verification
The hardest situation to reach from the ports is the interaction of the trigger pin with the mode bits. A trigger edge has to pass the synchronizer and land while the chosen mode is stable, with the counter frozen so that the captured or reloaded value is known. The stimulus freezes the counter by keeping the tick low and presetting both registers over the bus. It then drops the trigger pin for several cycles, under capture mode, reload mode, a disabled trigger and baud mode in turn. Baud strobes are counted by an edge-independent monitor across overflows that are forced from a preset value of 0xFFFF.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CRR  = 2'd2;

    typedef struct packed {
        logic ovf_flag;
        logic trg_flag;
        logic rx_sel;
        logic tx_sel;
        logic trg_en;
        logic run;
        logic pin_mode;
        logic cap_mode;
    } ctrl_t;

    function automatic logic baud_active(ctrl_t c);
        return c.rx_sel | c.tx_sel;
    endfunction

    function automatic logic reload_active(ctrl_t c);
        return baud_active(c) | ~c.cap_mode;
    endfunction
endpackage

// File: rtl/crt_fall_detect.sv
module crt_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b1;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/crt_count_core.sv
module crt_count_core
    import crt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic         cnt_wr,
    input  logic         crr_wr,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    input  logic         cnt_fall,
    input  logic         trg_fall,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] crr_q,
    output logic         ovf_set,
    output logic         trg_set,
    output logic         rx_strobe,
    output logic         tx_strobe
);
    logic         baud, autorel, step, wrap, trig, do_reload, do_capture;
    logic [W-1:0] cnt_d, crr_d;

    always_comb begin
        baud       = baud_active(ctrl);
        autorel    = reload_active(ctrl);
        step       = ctrl.run & (ctrl.pin_mode ? cnt_fall : tick);
        wrap       = step & (cnt_q == {W{1'b1}}) & ~cnt_wr;
        trig       = ctrl.trg_en & trg_fall & ~baud;
        do_reload  = (wrap & autorel) | (trig & ~ctrl.cap_mode);
        do_capture = trig & ctrl.cap_mode;

        if (cnt_wr)         cnt_d = wdata;
        else if (do_reload) cnt_d = crr_q;
        else if (step)      cnt_d = cnt_q + 1'b1;
        else                cnt_d = cnt_q;

        if (do_capture)     crr_d = cnt_q;
        else if (crr_wr)    crr_d = wdata;
        else                crr_d = crr_q;

        ovf_set = wrap & ~baud;
        trg_set = trig;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            crr_q     <= '0;
            rx_strobe <= 1'b0;
            tx_strobe <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            crr_q     <= crr_d;
            rx_strobe <= wrap & autorel & ctrl.rx_sel;
            tx_strobe <= wrap & autorel & ctrl.tx_sel;
        end
    end
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
    import crt_pkg::*;
#(
    parameter int W           = CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              tick_i,
    input  logic              count_pin_i,
    input  logic              trig_pin_i,
    output logic              irq_o,
    output logic              rx_baud_o,
    output logic              tx_baud_o
);
    ctrl_t        ctrl_q, ctrl_d;
    logic [W-1:0] cnt_q, crr_q;
    logic         ctrl_wr, cnt_wr, crr_wr;
    logic         cnt_fall, trg_fall, ovf_set, trg_set;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign cnt_wr  = bus_wr && (bus_addr == ADDR_CNT);
    assign crr_wr  = bus_wr && (bus_addr == ADDR_CRR);

    crt_fall_detect #(.STAGES(SYNC_STAGES)) u_cnt_pin (
        .clk(clk), .rst(rst), .pin_i(count_pin_i), .fall_o(cnt_fall)
    );

    crt_fall_detect #(.STAGES(SYNC_STAGES)) u_trg_pin (
        .clk(clk), .rst(rst), .pin_i(trig_pin_i), .fall_o(trg_fall)
    );

    crt_count_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl_q),
        .cnt_wr(cnt_wr), .crr_wr(crr_wr), .wdata(bus_wdata),
        .tick(tick_i), .cnt_fall(cnt_fall), .trg_fall(trg_fall),
        .cnt_q(cnt_q), .crr_q(crr_q),
        .ovf_set(ovf_set), .trg_set(trg_set),
        .rx_strobe(rx_baud_o), .tx_strobe(tx_baud_o)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (ovf_set) ctrl_d.ovf_flag = 1'b1;
        if (trg_set) ctrl_d.trg_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_CNT:  bus_rdata = cnt_q;
            ADDR_CRR:  bus_rdata = crr_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = ctrl_q.ovf_flag | ctrl_q.trg_flag;
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         ctrl_wr,
    input logic         cnt_wr,
    input logic [7:0]   ctrl,
    input logic [W-1:0] cnt,
    input logic         irq
);
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl[7] && !ctrl_wr |=> ctrl[7]);

    assert_trg_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl[6] && !ctrl_wr |=> ctrl[6]);

    assert_trg_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl[3] && !ctrl[6] && !ctrl_wr |=> !ctrl[6]);

    assert_baud_no_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl[5] || ctrl[4]) && !ctrl[7] && !ctrl_wr |=> !ctrl[7]);

    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl[2] && !ctrl[3] && !cnt_wr |=> $stable(cnt));

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($rose(ctrl[7]) || $rose(ctrl[6])));
endmodule

bind cr_timer16 crt_checker #(.W(W)) u_crt_checker (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr),
    .ctrl(ctrl_q), .cnt(cnt_q), .irq(irq_o)
);

// File: tb/cr_timer16_bench.sv
module cr_timer16_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_i = 1'b0;
    logic        count_pin_i = 1'b1;
    logic        trig_pin_i = 1'b1;
    logic        irq_o, rx_baud_o, tx_baud_o;

    int tests = 0;
    int fails = 0;
    int rx_pulses = 0;
    int tx_pulses = 0;

    always #4 clk = ~clk;

    cr_timer16 u_cr_timer16 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
        .count_pin_i(count_pin_i), .trig_pin_i(trig_pin_i),
        .irq_o(irq_o), .rx_baud_o(rx_baud_o), .tx_baud_o(tx_baud_o)
    );

    always @(negedge clk) begin
        if (rx_baud_o) rx_pulses++;
        if (tx_baud_o) tx_pulses++;
    end

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] cnt0;
        logic [15:0] crr0;
        logic [7:0]  ticks;
        logic [15:0] exp_cnt;
        logic [7:0]  exp_ctrl;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{8'h04, 16'h0010, 16'h0000, 8'd5, 16'h0015, 8'h04},  // R3 timer count
        '{8'h04, 16'hFFFE, 16'h1234, 8'd3, 16'h1235, 8'h84},  // R5 R6 reload
        '{8'h05, 16'hFFFF, 16'h5555, 8'd2, 16'h0001, 8'h85},  // R6 capture-mode roll
        '{8'h24, 16'hFFFF, 16'hFF00, 8'd1, 16'hFF00, 8'h24},  // R9 rx baud
        '{8'h15, 16'hFFFF, 16'hABCD, 8'd2, 16'hABCE, 8'h15},  // R9 tx baud, cap ignored
        '{8'h00, 16'h0100, 16'h0000, 8'd4, 16'h0100, 8'h00},  // R3 stopped
        '{8'h06, 16'h0200, 16'h0000, 8'd4, 16'h0200, 8'h06}   // R4 ticks ignored
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic drop_count_pin();
        @(negedge clk); count_pin_i = 1'b0;
        repeat (4) @(negedge clk);
        count_pin_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic drop_trig_pin();
        @(negedge clk); trig_pin_i = 1'b0;
        repeat (4) @(negedge clk);
        trig_pin_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int rx0, tx0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 16'h0000);
        rd(2'd1, d); check("R1 cnt", d, 16'h0000);
        rd(2'd2, d); check("R1 crr", d, 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);

        // vector table: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 16'h0000);
            wr(2'd2, VEC[i].crr0);
            wr(2'd1, VEC[i].cnt0);
            wr(2'd0, {8'h00, VEC[i].ctrl});
            for (int k = 0; k < int'(VEC[i].ticks); k++) pulse_tick();
            repeat (2) @(negedge clk);
            rd(2'd1, d); check("R3/R6 table cnt", d, VEC[i].exp_cnt);
            rd(2'd0, d); check("R5/R9 table ctrl", d, {8'h00, VEC[i].exp_ctrl});
        end

        // R11 irq follows flags, R5 software clear
        wr(2'd0, 16'h0080);
        check("R11 irq ovf", {15'd0, irq_o}, 16'h0001);
        wr(2'd0, 16'h0000);
        check("R11 irq clear", {15'd0, irq_o}, 16'h0000);

        // R4 counter mode via pin
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0006);
        repeat (3) drop_count_pin();
        rd(2'd1, d); check("R4 pin count", d, 16'h0003);

        // R7 capture on trigger
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h4000);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h000D);
        drop_trig_pin();
        rd(2'd2, d); check("R7 capture value", d, 16'h4000);
        rd(2'd0, d); check("R7 trigger flag", d, 16'h004D);
        check("R11 irq trigger", {15'd0, irq_o}, 16'h0001);

        // R7 reload on trigger
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h7777);
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h000C);
        drop_trig_pin();
        rd(2'd1, d); check("R7 reload value", d, 16'h7777);

        // R8 trigger disabled
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0004);
        drop_trig_pin();
        rd(2'd1, d); check("R8 cnt unchanged", d, 16'h0003);
        rd(2'd0, d); check("R8 no flag", d, 16'h0004);

        // R9 trigger ignored in baud mode
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h002D);
        drop_trig_pin();
        rd(2'd1, d); check("R9 trigger ignored cnt", d, 16'h0003);
        rd(2'd0, d); check("R9 trigger ignored flag", d, 16'h002D);

        // R10 baud strobes
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'hFFFF);
        wr(2'd1, 16'hFFFF);
        rx0 = rx_pulses; tx0 = tx_pulses;
        wr(2'd0, 16'h0024);
        pulse_tick();
        repeat (2) @(negedge clk);
        check("R10 rx strobe", 16'(rx_pulses - rx0), 16'd1);
        check("R10 tx quiet", 16'(tx_pulses - tx0), 16'd0);
        rx0 = rx_pulses; tx0 = tx_pulses;
        wr(2'd0, 16'h0014);
        pulse_tick();
        repeat (2) @(negedge clk);
        check("R10 tx strobe", 16'(tx_pulses - tx0), 16'd1);
        check("R10 rx quiet", 16'(rx_pulses - rx0), 16'd0);
        rx0 = rx_pulses; tx0 = tx_pulses;
        wr(2'd0, 16'h0005);
        wr(2'd1, 16'hFFFF);
        pulse_tick();
        repeat (2) @(negedge clk);
        check("R10 capture wrap no strobe", 16'(rx_pulses + tx_pulses - rx0 - tx0), 16'd0);

        // R12 counter write beats a tick in the same cycle
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'h0010);
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 16'h0500; bus_wr = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_i = 1'b0;
        rd(2'd1, d); check("R12 write priority", d, 16'h0500);

        // R2 unused address reads zero
        rd(2'd3, d); check("R2 unused addr", d, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule